// File: doc/BRIEF.md
# Delayed Transaction Completion Queue

This block sits inside a bus bridge and tracks delayed read and write requests. When an initiator on either bus issues a request that must be run on the opposite (far) bus, the bridge answers with retry and the block stores the request's command, address and originating side in a free slot. A forwarding engine hands stored requests one at a time to the far-bus master. When the far bus finishes, it reports either normal completion with data or master abort. The outcome is recorded against the slot.

When the initiator later repeats the request, the block compares it with every stored slot. For a slot that completed normally, it claims the transaction, returns the stored data and frees the slot. For a slot whose far-bus attempt was master-aborted, it deliberately withholds the claim (no DEVSEL#), so the initiator sees a master abort of its own, and it frees the slot. A master abort also sets a sticky received-master-abort flag for the bus on which the abort happened.

Three state machines drive the behaviour. The request machine goes RQ_IDLE → RQ_LOOKUP → RQ_RESPOND → RQ_IDLE: it captures a request, decides and updates the table, then presents the response for one cycle. The forwarding machine goes IS_IDLE → IS_SEND (when a slot is pending) → IS_WAIT (on fwd_ready) → IS_IDLE (on cpl_valid). Each slot moves E_FREE → E_PEND (on allocation) → E_ISSUED (on forwarding handshake) → E_OK or E_MA (on completion) → E_FREE (when the repeated request is answered).

Top module: `dly_txn_queue`

## Requirements
- R1: After reset, req_ready is 1, rsp_valid and fwd_valid are 0, both abort flags are 0, and every slot is free.
- R2: A request accepted while req_ready is 1 gets rsp_valid high for exactly one cycle, two clock edges after the accepting edge. req_ready is 0 from the accepting edge until rsp_valid drops. rsp_code is 0 for retry, 1 for claim with data, and 2 for no claim (master abort returned).
- R3: A request matches a slot only when both its command and its address equal the stored values. The same address with a different command is a separate transaction.
- R4: A request that matches no slot gets retry when a slot is free, and it is stored in the lowest-numbered free slot.
- R5: A request that matches no slot while all slots are in use gets retry and is not stored. It is never forwarded to the far bus.
- R6: A repeated request whose slot is still pending or on the far bus gets retry. No second slot is made and no extra forwarding happens.
- R7: The lowest-numbered pending slot is forwarded first, with only one forwarded transaction outstanding at a time. fwd_cmd, fwd_addr and fwd_sec (the originating side) stay fixed while fwd_valid is high and fwd_ready is low.
- R8: A repeated request whose slot completed normally gets claim with the stored completion data, and the slot is freed. A further repeat of it is a new request and gets retry.
- R9: A repeated request whose slot was master-aborted gets no claim, and the slot is freed. A further repeat gets retry and a new slot.
- R10: A master abort on a request that originated on the primary side sets rma_sec, and one that originated on the secondary side sets rma_pri. Both flags stay set until reset.
- R11: cpl_valid while no forwarded transaction is waiting for its outcome is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Repeated or new delayed request present |
| req_ready | output | 1 | Block can accept a request |
| req_sec | input | 1 | Request came from the secondary side (0 = primary) |
| req_cmd | input | CMD_W | Request command code |
| req_addr | input | ADDR_W | Request address |
| rsp_valid | output | 1 | Response strobe, one cycle |
| rsp_code | output | 2 | 0 retry, 1 claim, 2 no claim |
| rsp_data | output | DATA_W | Completion data on claim, else 0 |
| fwd_valid | output | 1 | A stored request is offered to the far bus |
| fwd_ready | input | 1 | Far-bus master takes the offered request |
| fwd_sec | output | 1 | Originating side of the offered request |
| fwd_cmd | output | CMD_W | Command of the offered request |
| fwd_addr | output | ADDR_W | Address of the offered request |
| cpl_valid | input | 1 | Far-bus outcome of the outstanding request |
| cpl_abort | input | 1 | Outcome was master abort |
| cpl_data | input | DATA_W | Completion data for normal outcome |
| rma_pri | output | 1 | Sticky: master abort received on primary bus |
| rma_sec | output | 1 | Sticky: master abort received on secondary bus |

## Verification
A slot left in the wrong state shows up on the first repeat of its request. A slot freed too early turns a claim into a retry. A slot freed too late shows up on the request after that, which gets a claim instead of a retry. A wrong slot or a stuck slot also appears on the forwarding port within a few cycles, as a duplicate offer, an out-of-order offer, or an offer for a request made while the queue was full. Abort bookkeeping on the wrong side shows up at once on the two flags after the completion edge.

// File: rtl/dtq_pkg.sv
package dtq_pkg;

    typedef enum logic [2:0] {
        E_FREE   = 3'd0,
        E_PEND   = 3'd1,
        E_ISSUED = 3'd2,
        E_OK     = 3'd3,
        E_MA     = 3'd4
    } ent_state_t;

    typedef enum logic [1:0] {
        RSP_RETRY   = 2'd0,
        RSP_CLAIM   = 2'd1,
        RSP_NOCLAIM = 2'd2
    } rsp_code_t;

    typedef enum logic [1:0] {
        RQ_IDLE    = 2'd0,
        RQ_LOOKUP  = 2'd1,
        RQ_RESPOND = 2'd2
    } rq_state_t;

    typedef enum logic [1:0] {
        IS_IDLE = 2'd0,
        IS_SEND = 2'd1,
        IS_WAIT = 2'd2
    } is_state_t;

endpackage

// File: rtl/dtq_pick.sv
module dtq_pick #(
    parameter int N     = 4,
    parameter int IDX_W = 2
) (
    input  logic [N-1:0]     vec,
    output logic             found,
    output logic [IDX_W-1:0] idx
);

    always_comb begin
        found = |vec;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) begin
                idx = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/dtq_match.sv
module dtq_match #(
    parameter int N      = 4,
    parameter int CMD_W  = 4,
    parameter int ADDR_W = 16
) (
    input  logic [N-1:0]             live,
    input  logic [N-1:0][CMD_W-1:0]  tbl_cmd,
    input  logic [N-1:0][ADDR_W-1:0] tbl_addr,
    input  logic [CMD_W-1:0]         key_cmd,
    input  logic [ADDR_W-1:0]        key_addr,
    output logic [N-1:0]             hit
);

    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign hit[g] = live[g]
                     && (tbl_cmd[g] == key_cmd)
                     && (tbl_addr[g] == key_addr);
    end

endmodule

// File: rtl/dtq_issue.sv
module dtq_issue
    import dtq_pkg::*;
#(
    parameter int N     = 4,
    parameter int IDX_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     pend_vec,
    input  logic             fwd_ready,
    input  logic             cpl_valid,
    output logic             fwd_valid,
    output logic [IDX_W-1:0] cur_idx,
    output logic             take,
    output logic             done
);

    is_state_t        st_q, st_d;
    logic             pend_found;
    logic [IDX_W-1:0] pend_idx;
    logic [IDX_W-1:0] idx_q;

    dtq_pick #(.N(N), .IDX_W(IDX_W)) i_pend_pick (
        .vec   (pend_vec),
        .found (pend_found),
        .idx   (pend_idx)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= IS_IDLE;
            idx_q <= '0;
        end else begin
            st_q <= st_d;
            if (st_q == IS_IDLE && pend_found) begin
                idx_q <= pend_idx;
            end
        end
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            IS_IDLE: if (pend_found) st_d = IS_SEND;
            IS_SEND: if (fwd_ready)  st_d = IS_WAIT;
            IS_WAIT: if (cpl_valid)  st_d = IS_IDLE;
            default: st_d = IS_IDLE;
        endcase
    end

    always_comb begin
        fwd_valid = (st_q == IS_SEND);
        take      = (st_q == IS_SEND) && fwd_ready;
        done      = (st_q == IS_WAIT) && cpl_valid;
        cur_idx   = idx_q;
    end

    // R7
    fwd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_valid && !fwd_ready) |=> (fwd_valid && $stable(cur_idx)));

    // R7
    one_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_valid && fwd_ready) |=> !fwd_valid);

    // R11
    cpl_only_waiting_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !fwd_valid);

endmodule

// File: rtl/dly_txn_queue.sv
module dly_txn_queue
    import dtq_pkg::*;
#(
    parameter int DEPTH  = 4,
    parameter int CMD_W  = 4,
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_sec,
    input  logic [CMD_W-1:0]  req_cmd,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              rsp_valid,
    output logic [1:0]        rsp_code,
    output logic [DATA_W-1:0] rsp_data,
    output logic              fwd_valid,
    input  logic              fwd_ready,
    output logic              fwd_sec,
    output logic [CMD_W-1:0]  fwd_cmd,
    output logic [ADDR_W-1:0] fwd_addr,
    input  logic              cpl_valid,
    input  logic              cpl_abort,
    input  logic [DATA_W-1:0] cpl_data,
    output logic              rma_pri,
    output logic              rma_sec
);

    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    // slot table
    ent_state_t                   ent_st [DEPTH];
    logic [DEPTH-1:0][CMD_W-1:0]  ent_cmd;
    logic [DEPTH-1:0][ADDR_W-1:0] ent_addr;
    logic [DEPTH-1:0][DATA_W-1:0] ent_data;
    logic [DEPTH-1:0]             ent_sec;

    logic [DEPTH-1:0] live_vec, free_vec, pend_vec, hit_vec;

    // captured request
    rq_state_t         rq_q, rq_d;
    logic [CMD_W-1:0]  q_cmd;
    logic [ADDR_W-1:0] q_addr;
    logic              q_sec;

    // lookup decision
    logic             hit_found, free_found;
    logic [IDX_W-1:0] hit_idx, free_idx;
    logic             alloc_en, release_en;
    rsp_code_t        dec_code;
    rsp_code_t        code_q;
    logic [DATA_W-1:0] data_q;

    // forwarding engine
    logic             take, done;
    logic [IDX_W-1:0] cur_idx;

    for (genvar g = 0; g < DEPTH; g++) begin : g_vec
        assign live_vec[g] = (ent_st[g] != E_FREE);
        assign free_vec[g] = (ent_st[g] == E_FREE);
        assign pend_vec[g] = (ent_st[g] == E_PEND);
    end

    dtq_match #(.N(DEPTH), .CMD_W(CMD_W), .ADDR_W(ADDR_W)) i_match (
        .live     (live_vec),
        .tbl_cmd  (ent_cmd),
        .tbl_addr (ent_addr),
        .key_cmd  (q_cmd),
        .key_addr (q_addr),
        .hit      (hit_vec)
    );

    dtq_pick #(.N(DEPTH), .IDX_W(IDX_W)) i_hit_pick (
        .vec   (hit_vec),
        .found (hit_found),
        .idx   (hit_idx)
    );

    dtq_pick #(.N(DEPTH), .IDX_W(IDX_W)) i_free_pick (
        .vec   (free_vec),
        .found (free_found),
        .idx   (free_idx)
    );

    dtq_issue #(.N(DEPTH), .IDX_W(IDX_W)) i_issue (
        .clk       (clk),
        .rst_n     (rst_n),
        .pend_vec  (pend_vec),
        .fwd_ready (fwd_ready),
        .cpl_valid (cpl_valid),
        .fwd_valid (fwd_valid),
        .cur_idx   (cur_idx),
        .take      (take),
        .done      (done)
    );

    // request state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rq_q <= RQ_IDLE;
        end else begin
            rq_q <= rq_d;
        end
    end

    always_comb begin
        rq_d = rq_q;
        unique case (rq_q)
            RQ_IDLE:    if (req_valid) rq_d = RQ_LOOKUP;
            RQ_LOOKUP:  rq_d = RQ_RESPOND;
            RQ_RESPOND: rq_d = RQ_IDLE;
            default:    rq_d = RQ_IDLE;
        endcase
    end

    // lookup decision
    always_comb begin
        dec_code   = RSP_RETRY;
        alloc_en   = 1'b0;
        release_en = 1'b0;
        if (rq_q == RQ_LOOKUP) begin
            if (hit_found) begin
                unique case (ent_st[hit_idx])
                    E_OK: begin
                        dec_code   = RSP_CLAIM;
                        release_en = 1'b1;
                    end
                    E_MA: begin
                        dec_code   = RSP_NOCLAIM;
                        release_en = 1'b1;
                    end
                    default: dec_code = RSP_RETRY;
                endcase
            end else if (free_found) begin
                alloc_en = 1'b1;
            end
        end
    end

    // request capture and response registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_cmd  <= '0;
            q_addr <= '0;
            q_sec  <= 1'b0;
            code_q <= RSP_RETRY;
            data_q <= '0;
        end else begin
            if (rq_q == RQ_IDLE && req_valid) begin
                q_cmd  <= req_cmd;
                q_addr <= req_addr;
                q_sec  <= req_sec;
            end
            if (rq_q == RQ_LOOKUP) begin
                code_q <= dec_code;
                data_q <= (dec_code == RSP_CLAIM) ? ent_data[hit_idx] : '0;
            end
        end
    end

    // slot table and abort flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                ent_st[i] <= E_FREE;
            end
            ent_cmd  <= '0;
            ent_addr <= '0;
            ent_data <= '0;
            ent_sec  <= '0;
            rma_pri  <= 1'b0;
            rma_sec  <= 1'b0;
        end else begin
            if (alloc_en) begin
                ent_st[free_idx]   <= E_PEND;
                ent_cmd[free_idx]  <= q_cmd;
                ent_addr[free_idx] <= q_addr;
                ent_sec[free_idx]  <= q_sec;
            end
            if (release_en) begin
                ent_st[hit_idx] <= E_FREE;
            end
            if (take) begin
                ent_st[cur_idx] <= E_ISSUED;
            end
            if (done) begin
                ent_st[cur_idx]   <= cpl_abort ? E_MA : E_OK;
                ent_data[cur_idx] <= cpl_abort ? '0 : cpl_data;
                if (cpl_abort) begin
                    if (ent_sec[cur_idx]) rma_pri <= 1'b1;
                    else                  rma_sec <= 1'b1;
                end
            end
        end
    end

    // outputs
    always_comb begin
        req_ready = (rq_q == RQ_IDLE);
        rsp_valid = (rq_q == RQ_RESPOND);
        rsp_code  = code_q;
        rsp_data  = data_q;
        fwd_cmd   = ent_cmd[cur_idx];
        fwd_addr  = ent_addr[cur_idx];
        fwd_sec   = ent_sec[cur_idx];
    end

    // R2
    rsp_one_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R2
    rsp_code_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_code != 2'd3));

    // R3
    no_dup_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rq_q == RQ_LOOKUP) |-> $onehot0(hit_vec));

    // R10
    rma_pri_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rma_pri |=> rma_pri);

    // R10
    rma_sec_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rma_sec |=> rma_sec);

    // R7
    fwd_fields_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_valid && !fwd_ready) |=> ($stable(fwd_addr) && $stable(fwd_cmd) && $stable(fwd_sec)));

endmodule

// File: tb/test_dly_txn_queue.sv
module test_dly_txn_queue;

    localparam int DEPTH  = 4;
    localparam int CMD_W  = 4;
    localparam int ADDR_W = 16;
    localparam int DATA_W = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic              req_sec = 1'b0;
    logic [CMD_W-1:0]  req_cmd = '0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic              rsp_valid;
    logic [1:0]        rsp_code;
    logic [DATA_W-1:0] rsp_data;
    logic              fwd_valid;
    logic              fwd_ready = 1'b0;
    logic              fwd_sec;
    logic [CMD_W-1:0]  fwd_cmd;
    logic [ADDR_W-1:0] fwd_addr;
    logic              cpl_valid = 1'b0;
    logic              cpl_abort = 1'b0;
    logic [DATA_W-1:0] cpl_data = '0;
    logic              rma_pri;
    logic              rma_sec;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit exp_pri = 1'b0;
    bit exp_sec = 1'b0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc++;

    dly_txn_queue #(.DEPTH(DEPTH), .CMD_W(CMD_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_dly_txn_queue (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_sec(req_sec),
        .req_cmd(req_cmd), .req_addr(req_addr),
        .rsp_valid(rsp_valid), .rsp_code(rsp_code), .rsp_data(rsp_data),
        .fwd_valid(fwd_valid), .fwd_ready(fwd_ready), .fwd_sec(fwd_sec),
        .fwd_cmd(fwd_cmd), .fwd_addr(fwd_addr),
        .cpl_valid(cpl_valid), .cpl_abort(cpl_abort), .cpl_data(cpl_data),
        .rma_pri(rma_pri), .rma_sec(rma_sec)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // issue one request, check handshake timing, return the response
    task automatic do_req(input bit sec, input logic [CMD_W-1:0] cmd, input logic [ADDR_W-1:0] addr,
                          output logic [1:0] code, output logic [DATA_W-1:0] data);
        for (int t = 0; t < 20 && !req_ready; t++) @(negedge clk);
        chk(req_ready, "R2 ready before request", 64'(req_ready), 1);
        req_valid = 1'b1; req_sec = sec; req_cmd = cmd; req_addr = addr;
        @(negedge clk);
        req_valid = 1'b0;
        chk(!rsp_valid && !req_ready, "R2 lookup cycle quiet", {62'd0, rsp_valid, req_ready}, 0);
        @(negedge clk);
        chk(rsp_valid, "R2 response strobe", 64'(rsp_valid), 1);
        code = rsp_code;
        data = rsp_data;
        @(negedge clk);
        chk(!rsp_valid && req_ready, "R2 strobe one cycle", {62'd0, rsp_valid, req_ready}, 1);
    endtask

    task automatic expect_req(input string tag, input bit sec, input logic [CMD_W-1:0] cmd,
                              input logic [ADDR_W-1:0] addr, input logic [1:0] ecode,
                              input logic [DATA_W-1:0] edata);
        logic [1:0] c;
        logic [DATA_W-1:0] d;
        do_req(sec, cmd, addr, c, d);
        chk(c == ecode, {tag, " code"}, 64'(c), 64'(ecode));
        if (ecode == 2'd1) chk(d == edata, {tag, " data"}, 64'(d), 64'(edata));
    endtask

    // take the offered request on the far bus and report an outcome
    task automatic serve(input string tag, input bit esec, input logic [CMD_W-1:0] ecmd,
                         input logic [ADDR_W-1:0] eaddr, input bit abort, input logic [DATA_W-1:0] data);
        for (int t = 0; t < 40 && !fwd_valid; t++) @(negedge clk);
        chk(fwd_valid, {tag, " offer"}, 64'(fwd_valid), 1);
        chk(fwd_addr == eaddr, {tag, " addr"}, 64'(fwd_addr), 64'(eaddr));
        chk(fwd_cmd == ecmd, {tag, " cmd"}, 64'(fwd_cmd), 64'(ecmd));
        chk(fwd_sec == esec, {tag, " side"}, 64'(fwd_sec), 64'(esec));
        fwd_ready = 1'b1;
        @(negedge clk);
        fwd_ready = 1'b0;
        chk(!fwd_valid, "R7 single outstanding", 64'(fwd_valid), 0);
        cpl_valid = 1'b1; cpl_abort = abort; cpl_data = data;
        @(negedge clk);
        cpl_valid = 1'b0; cpl_abort = 1'b0; cpl_data = '0;
        if (abort) begin
            if (esec) exp_pri = 1'b1;
            else      exp_sec = 1'b1;
        end
        chk(rma_pri == exp_pri && rma_sec == exp_sec, "R10 abort flags",
            {62'd0, rma_pri, rma_sec}, {62'd0, exp_pri, exp_sec});
    endtask

    task automatic no_offer(input string tag);
        bit seen = 1'b0;
        for (int t = 0; t < 8; t++) begin
            @(negedge clk);
            if (fwd_valid) seen = 1'b1;
        end
        chk(!seen, tag, 64'(seen), 0);
    endtask

    initial begin
        wait (cyc == 150000);
        errors++;
        $display("FAIL watchdog: actual cycle %0d expected finish earlier", cyc);
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        chk(req_ready && !rsp_valid && !fwd_valid && !rma_pri && !rma_sec, "R1 reset state",
            {59'd0, req_ready, rsp_valid, fwd_valid, rma_pri, rma_sec}, 64'h10);

        // R11: stray outcome while nothing is outstanding
        cpl_valid = 1'b1; cpl_abort = 1'b1; cpl_data = 32'hDEAD_BEEF;
        @(negedge clk);
        cpl_valid = 1'b0; cpl_abort = 1'b0; cpl_data = '0;
        @(negedge clk);
        chk(!rma_pri && !rma_sec && !fwd_valid, "R11 stray outcome ignored",
            {61'd0, rma_pri, rma_sec, fwd_valid}, 0);

        // basic flow, primary side
        expect_req("R4 new request retried", 1'b0, 4'h6, 16'h0040, 2'd0, '0);
        for (int t = 0; t < 10 && !fwd_valid; t++) @(negedge clk);
        expect_req("R6 repeat while pending", 1'b0, 4'h6, 16'h0040, 2'd0, '0);
        serve("R7 first offer", 1'b0, 4'h6, 16'h0040, 1'b0, 32'h1111_2222);
        no_offer("R6 no duplicate offer");
        expect_req("R8 claim after completion", 1'b0, 4'h6, 16'h0040, 2'd1, 32'h1111_2222);
        expect_req("R8 slot freed after claim", 1'b0, 4'h6, 16'h0040, 2'd0, '0);
        serve("R7 reissue", 1'b0, 4'h6, 16'h0040, 1'b1, '0);
        expect_req("R9 master abort not claimed", 1'b0, 4'h6, 16'h0040, 2'd2, '0);
        expect_req("R9 slot freed after abort", 1'b0, 4'h6, 16'h0040, 2'd0, '0);
        serve("R9 fresh slot offered", 1'b0, 4'h6, 16'h0040, 1'b0, 32'h3333_4444);
        expect_req("R8 claim fresh slot", 1'b0, 4'h6, 16'h0040, 2'd1, 32'h3333_4444);

        // R3: same address, different command
        expect_req("R3 first command", 1'b1, 4'h6, 16'h0080, 2'd0, '0);
        serve("R3 first offer", 1'b1, 4'h6, 16'h0080, 1'b0, 32'hAAAA_0006);
        expect_req("R3 other command not matched", 1'b1, 4'h7, 16'h0080, 2'd0, '0);
        serve("R3 second offer", 1'b1, 4'h7, 16'h0080, 1'b0, 32'hAAAA_0007);
        expect_req("R3 claim second command", 1'b1, 4'h7, 16'h0080, 2'd1, 32'hAAAA_0007);
        expect_req("R3 claim first command", 1'b1, 4'h6, 16'h0080, 2'd1, 32'hAAAA_0006);

        // R5: fill the queue, then overflow
        for (int k = 0; k < DEPTH; k++)
            expect_req("R4 fill slot", k[0], 4'h6, 16'h0200 + 16'(k * 4), 2'd0, '0);
        expect_req("R5 full queue retried", 1'b0, 4'h6, 16'h0300, 2'd0, '0);
        for (int k = 0; k < DEPTH; k++)
            serve("R7 lowest slot first", k[0], 4'h6, 16'h0200 + 16'(k * 4), 1'b0, 32'h5000_0000 + 32'(k));
        no_offer("R5 overflow request never offered");
        for (int k = 0; k < DEPTH; k++)
            expect_req("R8 claim filled slot", k[0], 4'h6, 16'h0200 + 16'(k * 4), 2'd1, 32'h5000_0000 + 32'(k));
        expect_req("R5 overflow request now stored", 1'b0, 4'h6, 16'h0300, 2'd0, '0);
        serve("R5 overflow offered later", 1'b0, 4'h6, 16'h0300, 1'b0, 32'h6000_0000);
        expect_req("R8 claim late slot", 1'b0, 4'h6, 16'h0300, 2'd1, 32'h6000_0000);

        // sweep over side, command and outcome
        for (int k = 0; k < 8; k++) begin
            logic [CMD_W-1:0]  cmd  = k[0] ? 4'h7 : 4'h6;
            logic [ADDR_W-1:0] addr = 16'h0400 + 16'(k * 4);
            logic [DATA_W-1:0] data = 32'hC0DE_0000 | 32'(k * 17);
            expect_req("R4 sweep request", k[1], cmd, addr, 2'd0, '0);
            serve("R10 sweep offer", k[1], cmd, addr, k[2], data);
            if (k[2]) expect_req("R9 sweep abort", k[1], cmd, addr, 2'd2, '0);
            else      expect_req("R8 sweep claim", k[1], cmd, addr, 2'd1, data);
        end
        no_offer("R9 sweep leaves queue empty");
        chk(rma_pri && rma_sec, "R10 both flags after sweep", {62'd0, rma_pri, rma_sec}, 3);

        summary();
    end

endmodule